// File: doc/BRIEF.md
# Two-Domain Seconds Counter with Alarm

The block keeps wall-clock time in a core that runs on a slow, always-on clock with its own reset. A down-counting divider reloads from a programmable prescaler. Each time it expires it produces one tick, and that tick advances a 32-bit seconds counter. The counter value is compared with an alarm value, and three event flags record ticks, counter wrap-around and alarm matches. Any flag whose enable bit is set drives a single interrupt output.

Software reaches the core through a register side that runs on a much faster bus clock and is reset by system reset. The bus side keeps copies of the counter, the divider and the event flags, and refreshes them once for every rising edge of the core clock, as seen after resynchronisation. A sync flag, cleared by software and set by hardware at the next refresh, shows when those copies can be trusted again. Writes to the prescaler, counter and alarm are held on the bus side and passed to the core through a toggle handshake.

Top module: `rtcnt_top`

## Requirements
- R1: With prescaler value P (PSC_W bits), the divider counts down from P to 0 and reloads P, so one tick occurs every P+1 core clock cycles.
- R2: Each tick adds one to the counter. A counter write (wr_sel 1) loads the written value and restarts the divider from the prescaler, and that cycle gives no tick.
- R3: The overflow flag (rd_flags bit 1) sets when a tick takes the counter from all ones to zero.
- R4: The alarm flag (rd_flags bit 2) sets when the counter value after a tick equals the alarm value (wr_sel 2). It stays set until software clears it.
- R5: The tick flag (rd_flags bit 0) sets at every tick.
- R6: A one in flag_clr clears the flag at the same bit position. Flags are sticky otherwise.
- R7: irq is high when any flag is set with its matching bit in the enable register (loaded from ien_data by ien_wr). System reset clears the enables, so irq is low after it.
- R8: rd_count and rd_div take the core counter and divider values once per resynchronised rising edge of core_clk. Flags from that core cycle are merged at the same refresh.
- R9: sync_clr drops sync_ok in the next bus cycle. sync_ok rises at the first refresh after the clear, and it is low after system reset.
- R10: A write (wr_sel 0 prescaler, 1 counter, 2 alarm) raises wr_busy until the core has taken it. A wr_en pulse while wr_busy is high is ignored. Each accepted write is applied exactly once.
- R11: System reset leaves the counter running. Backup reset (core_rst_n) sets the counter to 0, the prescaler to PSC_RST and the alarm to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| bus_rst_n | input | 1 | System reset, synchronous, active low |
| core_clk | input | 1 | Slow always-on core clock |
| core_rst_n | input | 1 | Backup reset, synchronous to core_clk, active low |
| wr_en | input | 1 | Write strobe for a core value |
| wr_sel | input | 2 | Write target: 0 prescaler, 1 counter, 2 alarm |
| wr_data | input | CNT_W | Write data |
| ien_wr | input | 1 | Load the interrupt enable register |
| ien_data | input | 3 | Enables: bit0 tick, bit1 overflow, bit2 alarm |
| flag_clr | input | 3 | Per-flag clear pulse, same bit order |
| sync_clr | input | 1 | Clear the sync flag |
| wr_busy | output | 1 | A write is in flight to the core |
| rd_count | output | CNT_W | Bus copy of the counter |
| rd_div | output | PSC_W | Bus copy of the divider |
| rd_flags | output | 3 | Event flags: bit0 tick, bit1 overflow, bit2 alarm |
| sync_ok | output | 1 | Bus copies refreshed since the last sync_clr |
| irq | output | 1 | OR of enabled flags |

## Verification
The counting path is swept over prescaler values 0 to 4. At each refresh the bench folds counter and divider into one elapsed-cycle number, count*(P+1)+(P-div), and expects it to grow by exactly one. This separates a wrong reload value, a wrong tick period and a missed or repeated refresh. The flags are tried near the all-ones boundary, across an alarm that the counter approaches and then passes, and over alternating tick/no-tick refreshes at P=3. These show whether a flag sets on the right edge and whether it stays set. Back-to-back writes, a system reset while the core runs and a backup reset while a completed write is still held then show whether writes are lost, doubled or applied again.

// File: rtl/rtcnt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the two-domain seconds counter.
// Assumes: flag bit order is used by software and by rd_flags/ien/flag_clr alike.
package rtcnt_pkg;
    typedef enum logic [1:0] {
        SEL_PSC  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_ALM  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_t;

    localparam int FLG_TICK = 0;
    localparam int FLG_OVF  = 1;
    localparam int FLG_ALM  = 2;
    localparam int NFLG     = 3;
endpackage

// File: rtl/rtcnt_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchroniser for single-bit signals crossing clock domains.
// Assumes: the input is a level or toggle that stays stable for several destination cycles.
module rtcnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rtcnt_core.sv
`timescale 1ns/1ps
// Core-domain time base: divider, seconds counter, alarm compare and event pulses.
// Assumes: req_sel/req_data are held stable by the bus side from the req_tgl toggle
// until ack_tgl returns. Events are held for exactly one core cycle.
module rtcnt_core
    import rtcnt_pkg::*;
#(
    parameter int          PSC_W   = 20,
    parameter int          CNT_W   = 32,
    parameter int unsigned PSC_RST = 32767
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    input  logic [1:0]       req_sel,
    input  logic [CNT_W-1:0] req_data,
    output logic             ack_tgl,
    output logic [CNT_W-1:0] cnt_q,
    output logic [PSC_W-1:0] div_q,
    output logic [NFLG-1:0]  ev_q
);
    localparam logic [PSC_W-1:0] PSC_INIT = PSC_W'(PSC_RST);

    logic             req_s;
    logic             seen_q;
    logic [PSC_W-1:0] presc_q;
    logic [CNT_W-1:0] alarm_q;
    logic             apply;
    wsel_t            sel;
    logic             wr_psc, wr_cnt, wr_alm;
    logic             tick;
    logic [CNT_W-1:0] cnt_next;

    rtcnt_sync #(.STAGES(2)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
    );

    assign apply    = (req_s != seen_q);
    assign sel      = wsel_t'(req_sel);
    assign wr_psc   = apply && (sel == SEL_PSC);
    assign wr_cnt   = apply && (sel == SEL_CNT);
    assign wr_alm   = apply && (sel == SEL_ALM);
    assign tick     = (div_q == '0);
    assign cnt_next = cnt_q + CNT_W'(1);
    assign ack_tgl  = seen_q;

    // Record the last request toggle taken; this doubles as the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_s;
    end

    // Hold the programmed prescaler and alarm values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= PSC_INIT;
            alarm_q <= '1;
        end else begin
            if (wr_psc) presc_q <= req_data[PSC_W-1:0];
            if (wr_alm) alarm_q <= req_data;
        end
    end

    // Divider and counter: a counter write restarts the period, else count down and tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= PSC_INIT;
            cnt_q <= '0;
        end else if (wr_cnt) begin
            div_q <= presc_q;
            cnt_q <= req_data;
        end else if (tick) begin
            div_q <= presc_q;
            cnt_q <= cnt_next;
        end else begin
            div_q <= div_q - PSC_W'(1);
        end
    end

    // One-cycle event pulses for tick, wrap and alarm match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q[FLG_TICK] <= tick && !wr_cnt;
            ev_q[FLG_OVF]  <= tick && !wr_cnt && (&cnt_q);
            ev_q[FLG_ALM]  <= tick && !wr_cnt && (cnt_next == alarm_q);
        end
    end

    // R1: the divider reloads the prescaler after reaching zero
    a_r1_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0 && !wr_cnt) |=> (div_q == $past(presc_q)));
    // R1: otherwise the divider steps down by one
    a_r1_down: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != '0 && !wr_cnt) |=> (div_q == $past(div_q) - PSC_W'(1)));
    // R2: a tick advances the counter by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0 && !wr_cnt) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    // R3: a wrap event leaves the counter at zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q[FLG_OVF] |-> (cnt_q == '0));
    // R4: an alarm event coincides with the counter equal to the alarm value
    a_r4_match: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q[FLG_ALM] |-> (cnt_q == $past(alarm_q)));
    // R5: a tick event always accompanies a counter step
    a_r5_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q[FLG_TICK] |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rtcnt_bus.sv
`timescale 1ns/1ps
// Bus-domain side: write launch with toggle handshake, refresh of core copies on
// each resynchronised core clock edge, sticky flags, enables, sync flag and irq.
// Assumes: bus_clk is at least four times core_clk, so core values are stable
// when the refresh samples them 2-3 bus cycles after a core edge.
module rtcnt_bus
    import rtcnt_pkg::*;
#(
    parameter int PSC_W = 20,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ien_wr,
    input  logic [NFLG-1:0]  ien_data,
    input  logic [NFLG-1:0]  flag_clr,
    input  logic             sync_clr,
    input  logic             core_clk_in,
    input  logic [CNT_W-1:0] core_cnt,
    input  logic [PSC_W-1:0] core_div,
    input  logic [NFLG-1:0]  core_ev,
    input  logic             core_ack,
    output logic             req_tgl,
    output logic [1:0]       req_sel,
    output logic [CNT_W-1:0] req_data,
    output logic             wr_busy,
    output logic [CNT_W-1:0] rd_count,
    output logic [PSC_W-1:0] rd_div,
    output logic [NFLG-1:0]  rd_flags,
    output logic             sync_ok,
    output logic             irq
);
    logic            cclk_s, cclk_d;
    logic            ack_s;
    logic            refresh;
    logic            pending_q;
    logic [NFLG-1:0] ien_q;

    rtcnt_sync #(.STAGES(2)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .d(core_clk_in), .q(cclk_s)
    );
    rtcnt_sync #(.STAGES(2)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(core_ack), .q(ack_s)
    );

    // Delay the resynchronised core clock to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cclk_d <= 1'b0;
        else        cclk_d <= cclk_s;
    end
    assign refresh = cclk_s && !cclk_d;

    // Launch one write at a time; park the target at SEL_NONE once acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            req_sel   <= SEL_NONE;
            req_data  <= '0;
            pending_q <= 1'b0;
        end else if (!pending_q) begin
            if (wr_en) begin
                req_tgl   <= !req_tgl;
                req_sel   <= wr_sel;
                req_data  <= wr_data;
                pending_q <= 1'b1;
            end
        end else if (ack_s == req_tgl) begin
            req_sel   <= SEL_NONE;
            pending_q <= 1'b0;
        end
    end
    assign wr_busy = pending_q;

    // Copy counter and divider at each refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_count <= '0;
            rd_div   <= '0;
        end else if (refresh) begin
            rd_count <= core_cnt;
            rd_div   <= core_div;
        end
    end

    // Sticky flags: software clears, a refresh merges the core events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) rd_flags <= '0;
        else        rd_flags <= (rd_flags & ~flag_clr) | (refresh ? core_ev : '0);
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_data;
    end

    // Sync flag: cleared by software, set by the next refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)        sync_ok <= 1'b0;
        else if (sync_clr) sync_ok <= 1'b0;
        else if (refresh)  sync_ok <= 1'b1;
    end

    // Registered interrupt from enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(rd_flags & ien_q);
    end

    // R10: request toggle and data hold while the write is unacknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && (ack_s != req_tgl)) |=> ($stable(req_data) && $stable(req_tgl)));
    // R9: a clear always drops the sync flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> !sync_ok);
    // R6: a cleared flag stays clear unless a refresh sets it again
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> ((rd_flags & $past(flag_clr)) == '0));
    // R7: no enabled flag means no interrupt
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_flags & ien_q) == '0) |=> !irq);
endmodule

// File: rtl/rtcnt_top.sv
`timescale 1ns/1ps
// Two-domain seconds counter with alarm: core on core_clk/core_rst_n,
// register side on bus_clk/bus_rst_n.
// Assumes: bus_clk runs at least four times faster than core_clk.
module rtcnt_top
    import rtcnt_pkg::*;
#(
    parameter int          PSC_W   = 20,
    parameter int          CNT_W   = 32,
    parameter int unsigned PSC_RST = 32767
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             core_clk,
    input  logic             core_rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ien_wr,
    input  logic [2:0]       ien_data,
    input  logic [2:0]       flag_clr,
    input  logic             sync_clr,
    output logic             wr_busy,
    output logic [CNT_W-1:0] rd_count,
    output logic [PSC_W-1:0] rd_div,
    output logic [2:0]       rd_flags,
    output logic             sync_ok,
    output logic             irq
);
    logic             req_tgl, ack_tgl;
    logic [1:0]       req_sel;
    logic [CNT_W-1:0] req_data;
    logic [CNT_W-1:0] core_cnt;
    logic [PSC_W-1:0] core_div;
    logic [NFLG-1:0]  core_ev;

    rtcnt_core #(.PSC_W(PSC_W), .CNT_W(CNT_W), .PSC_RST(PSC_RST)) u_core (
        .clk(core_clk), .rst_n(core_rst_n),
        .req_tgl(req_tgl), .req_sel(req_sel), .req_data(req_data),
        .ack_tgl(ack_tgl), .cnt_q(core_cnt), .div_q(core_div), .ev_q(core_ev)
    );

    rtcnt_bus #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ien_wr(ien_wr), .ien_data(ien_data), .flag_clr(flag_clr),
        .sync_clr(sync_clr), .core_clk_in(core_clk),
        .core_cnt(core_cnt), .core_div(core_div), .core_ev(core_ev),
        .core_ack(ack_tgl),
        .req_tgl(req_tgl), .req_sel(req_sel), .req_data(req_data),
        .wr_busy(wr_busy), .rd_count(rd_count), .rd_div(rd_div),
        .rd_flags(rd_flags), .sync_ok(sync_ok), .irq(irq)
    );
endmodule

// File: tb/rtcnt_top_bench.sv
`timescale 1ns/1ps
// Self-checking bench: core clock 16x slower than the 200 MHz bus clock, PSC_RST = 3.
module rtcnt_top_bench;
    logic        bus_clk = 1'b0;
    logic        core_clk = 1'b0;
    logic        bus_rst_n, core_rst_n;
    logic        wr_en, ien_wr, sync_clr;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [2:0]  ien_data, flag_clr;
    logic        wr_busy, sync_ok, irq;
    logic [31:0] rd_count;
    logic [19:0] rd_div;
    logic [2:0]  rd_flags;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] c, c_old, c0;
    logic [19:0] d;
    logic [2:0]  f;
    longint      prev;

    always #2.5 bus_clk = ~bus_clk;
    always #40  core_clk = ~core_clk;

    rtcnt_top #(.PSC_W(20), .CNT_W(32), .PSC_RST(3)) u_rtcnt_top (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .core_clk(core_clk),
        .core_rst_n(core_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ien_wr(ien_wr), .ien_data(ien_data),
        .flag_clr(flag_clr), .sync_clr(sync_clr), .wr_busy(wr_busy),
        .rd_count(rd_count), .rd_div(rd_div), .rd_flags(rd_flags),
        .sync_ok(sync_ok), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic sample();
        @(negedge bus_clk) sync_clr = 1'b1;
        @(negedge bus_clk) sync_clr = 1'b0;
        while (!sync_ok) @(negedge bus_clk);
        c = rd_count; d = rd_div; f = rd_flags;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge bus_clk); wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge bus_clk); wr_en = 1'b0;
        while (wr_busy) @(negedge bus_clk);
    endtask

    task automatic clear_flags(input logic [2:0] m);
        @(negedge bus_clk) flag_clr = m;
        @(negedge bus_clk) flag_clr = 3'b000;
    endtask

    task automatic set_ien(input logic [2:0] m);
        @(negedge bus_clk); ien_wr = 1'b1; ien_data = m;
        @(negedge bus_clk) ien_wr = 1'b0;
    endtask

    function automatic longint pos(input logic [31:0] cv, input logic [19:0] dv, input int p);
        return longint'(cv) * (p + 1) + (p - longint'(dv));
    endfunction

    initial begin
        repeat (150000) @(posedge bus_clk);
        checks++; errors++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bus_rst_n = 1'b0; core_rst_n = 1'b0;
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
        ien_wr = 1'b0; ien_data = '0; flag_clr = '0; sync_clr = 1'b0;
        repeat (4) @(posedge core_clk);
        @(negedge bus_clk); bus_rst_n = 1'b1; core_rst_n = 1'b1;
        @(negedge bus_clk);
        chk(sync_ok == 1'b0, "R9 sync low after reset", sync_ok, 0);
        chk(irq == 1'b0, "R7 irq low after reset", irq, 0);
        chk(rd_flags == 3'b000, "R6 flags clear after reset", rd_flags, 0);
        chk(wr_busy == 1'b0, "R10 idle after reset", wr_busy, 0);
        sample();
        chk(c <= 1, "R11 counter starts at zero", c, 0);
        @(negedge bus_clk) sync_clr = 1'b1;
        @(negedge bus_clk) sync_clr = 1'b0;
        chk(sync_ok == 1'b0, "R9 clear drops sync", sync_ok, 0);

        // R1 R2 R8: sweep prescaler values, elapsed cycles grow by one per refresh
        for (int p = 0; p < 5; p++) begin
            wr(2'd0, 32'(p));
            wr(2'd1, 32'd100);
            sample();
            chk(c >= 100 && c <= 102, "R2 counter load", c, 100);
            chk(d <= 20'(p), "R1 divider range", d, p);
            prev = pos(c, d, p);
            for (int k = 0; k < 5; k++) begin
                sample();
                chk(pos(c, d, p) == prev + 1, "R1 R8 one cycle per refresh", pos(c, d, p), prev + 1);
                prev = pos(c, d, p);
            end
        end

        // R5: tick flag tracks counter steps at P=3
        wr(2'd0, 32'd3);
        sample();
        for (int k = 0; k < 8; k++) begin
            c_old = c;
            clear_flags(3'b111);
            sample();
            chk(f[0] == (c != c_old), "R5 tick flag", f[0], c != c_old);
        end

        // R3: wrap from all ones
        wr(2'd0, 32'd0);
        wr(2'd1, 32'hFFFF_FFFD);
        clear_flags(3'b111);
        for (int k = 0; k < 6; k++) begin
            sample();
            chk(f[1] == (c < 32'd16), "R3 overflow flag", f[1], c < 32'd16);
        end

        // R4: alarm sets on match and stays set
        wr(2'd0, 32'd1);
        wr(2'd2, 32'd500);
        wr(2'd1, 32'd495);
        clear_flags(3'b111);
        for (int k = 0; k < 15; k++) begin
            sample();
            chk(f[2] == (c >= 32'd500), "R4 alarm flag", f[2], c >= 32'd500);
        end

        // R7: irq follows enabled flags
        set_ien(3'b100); cyc(3);
        chk(irq == 1'b1, "R7 alarm enabled", irq, 1);
        set_ien(3'b010); cyc(3);
        chk(irq == 1'b0, "R7 overflow enabled, flag clear", irq, 0);
        set_ien(3'b001); cyc(3);
        chk(irq == 1'b1, "R7 tick enabled", irq, 1);
        set_ien(3'b000); cyc(3);
        chk(irq == 1'b0, "R7 nothing enabled", irq, 0);

        // R6: clearing only the alarm flag
        clear_flags(3'b100);
        sample();
        chk(f[2] == 1'b0, "R6 alarm flag cleared", f[2], 0);

        // R10: second strobe while busy is ignored
        wr(2'd0, 32'd0);
        @(negedge bus_clk); wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'd1000;
        @(negedge bus_clk); wr_data = 32'd5000;
        @(negedge bus_clk); wr_en = 1'b0;
        chk(wr_busy == 1'b1, "R10 busy during transfer", wr_busy, 1);
        while (wr_busy) @(negedge bus_clk);
        sample();
        chk(c >= 1000 && c <= 1004, "R10 busy strobe ignored", c, 1000);
        prev = pos(c, d, 0);
        for (int k = 0; k < 3; k++) begin
            sample();
            chk(pos(c, d, 0) == prev + 1, "R10 write applied once", pos(c, d, 0), prev + 1);
            prev = pos(c, d, 0);
        end

        // R11 R9 R7: system reset while the core runs
        set_ien(3'b111);
        sample();
        c0 = c;
        @(negedge bus_clk) bus_rst_n = 1'b0;
        cyc(4);
        bus_rst_n = 1'b1;
        @(negedge bus_clk);
        chk(sync_ok == 1'b0, "R9 sync low after system reset", sync_ok, 0);
        chk(irq == 1'b0, "R7 enables cleared by system reset", irq, 0);
        sample();
        chk(c >= c0 && c <= c0 + 4, "R11 counter survives system reset", c, c0);
        sample(); sample(); sample();
        wr(2'd1, 32'd7000);
        sample();
        chk(c >= 7000 && c <= 7003, "R10 write after system reset", c, 7000);

        // R11: backup reset restores counter, prescaler and alarm
        @(negedge bus_clk) core_rst_n = 1'b0;
        repeat (3) @(posedge core_clk);
        @(negedge bus_clk) core_rst_n = 1'b1;
        clear_flags(3'b111);
        sample();
        chk(c <= 2, "R11 counter zero after backup reset", c, 0);
        prev = pos(c, d, 3);
        for (int k = 0; k < 4; k++) begin
            sample();
            chk(pos(c, d, 3) == prev + 1, "R11 prescaler back to reset value", pos(c, d, 3), prev + 1);
            prev = pos(c, d, 3);
        end
        chk(f[2] == 1'b0, "R11 alarm back to all ones", f[2], 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule